// File: doc/BRIEF.md
# Composite Sync Timing Generator

This block produces the sync timing for a progressive, PAL-style composite video frame. Every duration is an exact count of cycles of a 24 MHz clock. A frame starts with a train of long vertical sync pulses. A fixed number of picture lines follows, each made of a horizontal sync tip, a back porch and an active picture window. A train of short sync pulses comes next, and a one-cycle marker cycle closes the frame. The next frame begins on the following cycle.

The sync output is one logic bit. Low is the sync tip level (0 V) and high is the black level (0.3 V). An external resistor network converts it to the analog levels. Alongside sync, the block drives four outputs:

- a window strobe that is high during the active picture time;
- a picture-line index;
- a frame-start pulse;
- a per-frame marker pulse, useful for triggering an oscilloscope.

A pixel shifter uses these outputs to place its data. Every pin is a plain control or timing signal. No pin carries a data stream, so there is no handshake and no back-pressure.

Top module: `pal_csync_gen`

## Requirements
- R1: Each frame opens with LONG_CNT (default 5) long pulses in a row. In each one, `sync_n` is low for LONG_LO_CYC (default 719) cycles and then high for LONG_HI_CYC (default 48) cycles.
- R2: LINE_CNT (default 152) picture lines follow. Each line has `sync_n` low for HSYNC_CYC (96) cycles, then high for PORCH_CYC (192) cycles, then high for ACTIVE_CYC (1247) cycles. `line_active` is 1 in exactly those ACTIVE_CYC cycles and 0 in all other cycles.
- R3: `line_idx` equals LINE_CNT-1 for the whole of the first picture line and counts down by one per line to 0 on the last line. Outside the picture lines it is 0.
- R4: After the last picture line come SHORT_CNT (default 6) short pulses. In each one, `sync_n` is low for SHORT_LO_CYC (48) cycles and then high for SHORT_HI_CYC (720) cycles.
- R5: After the last short pulse, `dbg_pulse` is 1 for exactly one cycle, with `sync_n` high. The first long pulse of the next frame starts on the cycle after that.
- R6: `frame_start` is 1 only on the first cycle of the first long pulse of each frame.
- R7: While `rst` (synchronous, active high) is 1, the outputs hold `sync_n`=1, `line_active`=0, `frame_start`=0, `dbg_pulse`=0 and `line_idx`=0. The first cycle with `rst`=0 is the first cycle of a new frame.
- R8: `line_active` is never 1 while `sync_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz timing clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | output | 1 | Composite sync: 0 = sync tip, 1 = black level |
| line_active | output | 1 | High during the active picture window of a line |
| line_idx | output | LINE_W (8) | Remaining-line index, LINE_CNT-1 down to 0 |
| frame_start | output | 1 | First cycle of the frame's first long pulse |
| dbg_pulse | output | 1 | One-cycle marker after the trailing short pulses |

## Verification
The bench compares every output on every cycle against a cycle-position model of the frame. It runs with short pulse lengths so that many complete frames fit in the run, and it forces resets at random points and once in the middle of an active window.

The seams between phases are where errors would show:
- A design with an off-by-one in the repeat count would emit an extra or missing long pulse, line or short pulse. That shifts every later edge.
- A design that stretched the marker would delay the next `frame_start`.
- A design that failed to reload its counters on reset would resume in the middle of a line rather than at the first long pulse.

// File: rtl/pal_csync_pkg.sv
package pal_csync_pkg;

  typedef enum logic [2:0] {
    PH_LVS_LO,   // long vertical pulse, tip
    PH_LVS_HI,   // long vertical pulse, black
    PH_HS,       // line sync tip
    PH_BP,       // back porch
    PH_ACT,      // active window
    PH_SVS_LO,   // short vertical pulse, tip
    PH_SVS_HI,   // short vertical pulse, black
    PH_MARK      // one-cycle frame marker
  } phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pal_seg_timer.sv
module pal_seg_timer #(
  parameter int W     = 11,
  parameter int START = 719
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] next_len,
  output logic [W-1:0] cnt,
  output logic         expire
);

  // Counts down from length-1; the final cycle of a segment loads the next.
  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= W'(START - 1);
    else if (expire)
      cnt <= next_len - W'(1);
    else
      cnt <= cnt - W'(1);
  end

endmodule

// File: rtl/pal_phase_seq.sv
module pal_phase_seq
  import pal_csync_pkg::*;
#(
  parameter int LEN_W        = 11,
  parameter int REP_W        = 8,
  parameter int LONG_LO_CYC  = 719,
  parameter int LONG_HI_CYC  = 48,
  parameter int SHORT_LO_CYC = 48,
  parameter int SHORT_HI_CYC = 720,
  parameter int HSYNC_CYC    = 96,
  parameter int PORCH_CYC    = 192,
  parameter int ACTIVE_CYC   = 1247,
  parameter int LONG_CNT     = 5,
  parameter int SHORT_CNT    = 6,
  parameter int LINE_CNT     = 152
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  output phase_e           phase,
  output logic [REP_W-1:0] rep,
  output logic [LEN_W-1:0] next_len
);

  phase_e           ph_nxt;
  logic [REP_W-1:0] rep_nxt;

  // Phase order and repeat bookkeeping; rep counts remaining repeats.
  always_comb begin
    ph_nxt  = phase;
    rep_nxt = rep;
    unique case (phase)
      PH_LVS_LO: ph_nxt = PH_LVS_HI;
      PH_LVS_HI: begin
        if (rep == '0) begin
          ph_nxt  = PH_HS;
          rep_nxt = REP_W'(LINE_CNT - 1);
        end else begin
          ph_nxt  = PH_LVS_LO;
          rep_nxt = rep - REP_W'(1);
        end
      end
      PH_HS: ph_nxt = PH_BP;
      PH_BP: ph_nxt = PH_ACT;
      PH_ACT: begin
        if (rep == '0) begin
          ph_nxt  = PH_SVS_LO;
          rep_nxt = REP_W'(SHORT_CNT - 1);
        end else begin
          ph_nxt  = PH_HS;
          rep_nxt = rep - REP_W'(1);
        end
      end
      PH_SVS_LO: ph_nxt = PH_SVS_HI;
      PH_SVS_HI: begin
        if (rep == '0) begin
          ph_nxt = PH_MARK;
        end else begin
          ph_nxt  = PH_SVS_LO;
          rep_nxt = rep - REP_W'(1);
        end
      end
      PH_MARK: begin
        ph_nxt  = PH_LVS_LO;
        rep_nxt = REP_W'(LONG_CNT - 1);
      end
    endcase
  end

  // Length of the segment about to begin.
  always_comb begin
    unique case (ph_nxt)
      PH_LVS_LO: next_len = LEN_W'(LONG_LO_CYC);
      PH_LVS_HI: next_len = LEN_W'(LONG_HI_CYC);
      PH_HS:     next_len = LEN_W'(HSYNC_CYC);
      PH_BP:     next_len = LEN_W'(PORCH_CYC);
      PH_ACT:    next_len = LEN_W'(ACTIVE_CYC);
      PH_SVS_LO: next_len = LEN_W'(SHORT_LO_CYC);
      PH_SVS_HI: next_len = LEN_W'(SHORT_HI_CYC);
      PH_MARK:   next_len = LEN_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LVS_LO;
      rep   <= REP_W'(LONG_CNT - 1);
    end else if (expire) begin
      phase <= ph_nxt;
      rep   <= rep_nxt;
    end
  end

endmodule

// File: rtl/pal_sync_decode.sv
module pal_sync_decode
  import pal_csync_pkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int REP_W       = 8,
  parameter int LINE_W      = 8,
  parameter int LONG_LO_CYC = 719,
  parameter int LONG_CNT    = 5
) (
  input  logic              rst,
  input  phase_e            phase,
  input  logic [REP_W-1:0]  rep,
  input  logic [LEN_W-1:0]  cnt,
  output logic              sync_n,
  output logic              line_active,
  output logic [LINE_W-1:0] line_idx,
  output logic              frame_start,
  output logic              dbg_pulse
);

  logic tip, picture, first_cyc;

  assign tip     = (phase == PH_LVS_LO) || (phase == PH_HS) || (phase == PH_SVS_LO);
  assign picture = (phase == PH_HS) || (phase == PH_BP) || (phase == PH_ACT);
  assign first_cyc = (phase == PH_LVS_LO) && (rep == REP_W'(LONG_CNT - 1))
                  && (cnt == LEN_W'(LONG_LO_CYC - 1));

  // Reset overrides every output so the line idles at black level.
  assign sync_n      = rst || !tip;
  assign line_active = !rst && (phase == PH_ACT);
  assign dbg_pulse   = !rst && (phase == PH_MARK);
  assign frame_start = !rst && first_cyc;
  assign line_idx    = (rst || !picture) ? '0 : rep[LINE_W-1:0];

endmodule

// File: rtl/pal_csync_gen.sv
module pal_csync_gen
  import pal_csync_pkg::*;
#(
  parameter int LONG_LO_CYC  = 719,
  parameter int LONG_HI_CYC  = 48,
  parameter int SHORT_LO_CYC = 48,
  parameter int SHORT_HI_CYC = 720,
  parameter int HSYNC_CYC    = 96,
  parameter int PORCH_CYC    = 192,
  parameter int ACTIVE_CYC   = 1247,
  parameter int LONG_CNT     = 5,
  parameter int SHORT_CNT    = 6,
  parameter int LINE_CNT     = 152,
  localparam int LINE_W      = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sync_n,
  output logic              line_active,
  output logic [LINE_W-1:0] line_idx,
  output logic              frame_start,
  output logic              dbg_pulse
);

  localparam int LEN_MAX = max_of(max_of(max_of(LONG_LO_CYC, LONG_HI_CYC),
                                         max_of(SHORT_LO_CYC, SHORT_HI_CYC)),
                                  max_of(max_of(HSYNC_CYC, PORCH_CYC), ACTIVE_CYC));
  localparam int LEN_W   = $clog2(LEN_MAX + 1);
  localparam int REP_MAX = max_of(max_of(LONG_CNT, SHORT_CNT), LINE_CNT);
  localparam int REP_W   = $clog2(REP_MAX + 1);

  phase_e           phase;
  logic [REP_W-1:0] rep;
  logic [LEN_W-1:0] cnt, next_len;
  logic             expire;

  pal_seg_timer #(
    .W(LEN_W), .START(LONG_LO_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .next_len(next_len), .cnt(cnt), .expire(expire)
  );

  pal_phase_seq #(
    .LEN_W(LEN_W), .REP_W(REP_W),
    .LONG_LO_CYC(LONG_LO_CYC), .LONG_HI_CYC(LONG_HI_CYC),
    .SHORT_LO_CYC(SHORT_LO_CYC), .SHORT_HI_CYC(SHORT_HI_CYC),
    .HSYNC_CYC(HSYNC_CYC), .PORCH_CYC(PORCH_CYC), .ACTIVE_CYC(ACTIVE_CYC),
    .LONG_CNT(LONG_CNT), .SHORT_CNT(SHORT_CNT), .LINE_CNT(LINE_CNT)
  ) u_seq (
    .clk(clk), .rst(rst), .expire(expire),
    .phase(phase), .rep(rep), .next_len(next_len)
  );

  pal_sync_decode #(
    .LEN_W(LEN_W), .REP_W(REP_W), .LINE_W(LINE_W),
    .LONG_LO_CYC(LONG_LO_CYC), .LONG_CNT(LONG_CNT)
  ) u_dec (
    .rst(rst), .phase(phase), .rep(rep), .cnt(cnt),
    .sync_n(sync_n), .line_active(line_active), .line_idx(line_idx),
    .frame_start(frame_start), .dbg_pulse(dbg_pulse)
  );

endmodule

// File: rtl/pal_csync_chk.sv
module pal_csync_chk #(
  parameter int LONG_LO_CYC  = 719,
  parameter int SHORT_LO_CYC = 48,
  parameter int HSYNC_CYC    = 96,
  parameter int ACTIVE_CYC   = 1247
) (
  input logic clk,
  input logic rst,
  input logic sync_n,
  input logic line_active,
  input logic frame_start,
  input logic dbg_pulse
);

  int act_run, low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_run <= 0;
      low_run <= 0;
    end else begin
      act_run <= line_active ? act_run + 1 : 0;
      low_run <= !sync_n ? low_run + 1 : 0;
    end
  end

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    rst |-> (sync_n && !line_active && !frame_start && !dbg_pulse));

  // R8
  no_active_tip_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_active && !sync_n));

  // R5
  mark_single_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_pulse |=> !dbg_pulse);

  // R5
  mark_then_frame_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_pulse |=> frame_start);

  // R6
  frame_start_tip_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (!sync_n && !line_active));

  // R2
  active_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(line_active) |-> (act_run == ACTIVE_CYC));

  // R1
  tip_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> (low_run == LONG_LO_CYC || low_run == HSYNC_CYC ||
                       low_run == SHORT_LO_CYC));

endmodule

bind pal_csync_gen pal_csync_chk #(
  .LONG_LO_CYC(LONG_LO_CYC), .SHORT_LO_CYC(SHORT_LO_CYC),
  .HSYNC_CYC(HSYNC_CYC), .ACTIVE_CYC(ACTIVE_CYC)
) u_pal_csync_chk (
  .clk(clk), .rst(rst), .sync_n(sync_n), .line_active(line_active),
  .frame_start(frame_start), .dbg_pulse(dbg_pulse)
);

// File: tb/test_pal_csync_gen.sv
`timescale 1ns/1ps
module test_pal_csync_gen;

  localparam int LL = 7, LH = 3, SL = 2, SH = 6, HS = 3, BP = 4, AC = 9;
  localparam int NL = 5, NS = 6, NLN = 4;
  localparam int LP = LL + LH, SP = SL + SH, LN = HS + BP + AC;
  localparam int FRAME = NL*LP + NLN*LN + NS*SP + 1;
  localparam int IDX_W = 2;
  localparam int DIR_C = 2*FRAME + NL*LP + HS + BP + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n, line_active, frame_start, dbg_pulse;
  logic [IDX_W-1:0] line_idx;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pal_csync_gen #(
    .LONG_LO_CYC(LL), .LONG_HI_CYC(LH), .SHORT_LO_CYC(SL), .SHORT_HI_CYC(SH),
    .HSYNC_CYC(HS), .PORCH_CYC(BP), .ACTIVE_CYC(AC),
    .LONG_CNT(NL), .SHORT_CNT(NS), .LINE_CNT(NLN)
  ) i_pal_csync_gen (
    .clk(clk), .rst(rst), .sync_n(sync_n), .line_active(line_active),
    .line_idx(line_idx), .frame_start(frame_start), .dbg_pulse(dbg_pulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected outputs at cycle t counted from the first cycle after reset.
  function automatic void model(input int t, output int s, output int a, output int f,
                                output int d, output int idx, output string tag);
    int u, v, w;
    u = t % FRAME;
    s = 1; a = 0; f = 0; d = 0; idx = 0; tag = "R5";
    if (u < NL*LP) begin
      tag = "R1";
      s = ((u % LP) >= LL) ? 1 : 0;
      f = (u == 0) ? 1 : 0;
    end else if (u < NL*LP + NLN*LN) begin
      v = u - NL*LP;
      w = v % LN;
      tag = "R2";
      idx = NLN - 1 - v / LN;
      s = (w >= HS) ? 1 : 0;
      a = (w >= HS + BP) ? 1 : 0;
    end else if (u < NL*LP + NLN*LN + NS*SP) begin
      v = u - NL*LP - NLN*LN;
      tag = "R4";
      s = ((v % SP) >= SL) ? 1 : 0;
    end else begin
      d = 1;
    end
  endfunction

  initial begin
    int t, hold, es, ea, ef, ed, ei;
    string tag;
    t = 0;
    hold = 0;
    void'($urandom(32'd2024));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 3200; c++) begin
      if (hold == 0) begin
        if (c == DIR_C) hold = 2;                 // reset inside an active window
        else if (c > 2*FRAME && $urandom_range(0, 149) == 0)
          hold = $urandom_range(1, 3);
      end
      rst = (hold > 0);
      #1;
      if (rst) begin
        chk("R7", "sync_n", int'(sync_n), 1);
        chk("R7", "line_active", int'(line_active), 0);
        chk("R7", "frame_start", int'(frame_start), 0);
        chk("R7", "dbg_pulse", int'(dbg_pulse), 0);
        chk("R7", "line_idx", int'(line_idx), 0);
      end else begin
        model(t, es, ea, ef, ed, ei, tag);
        chk(tag, "sync_n", int'(sync_n), es);
        chk("R2", "line_active", int'(line_active), ea);
        chk("R6", "frame_start", int'(frame_start), ef);
        chk("R5", "dbg_pulse", int'(dbg_pulse), ed);
        chk("R3", "line_idx", int'(line_idx), ei);
        chk("R8", "active_during_tip", int'(line_active && !sync_n), 0);
      end
      @(negedge clk);
      if (hold > 0) begin
        hold--;
        t = 0;
      end else begin
        t++;
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule